// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block keeps the per-channel mode and status byte for a small DMA controller with a parameterised number of channels (four by default). Software reaches one channel at a time through an 8-bit register port addressed by a channel index. A write mask allows a full byte write or a single-bit write. A transfer engine, outside this block, reports terminal count, last-cycle state, forced-termination acknowledge, suspension, and incoming requests. The block drives enable, multi-link mode and one-cycle trigger and init strobes back to that engine.

Field layout of each channel byte: bit 0 is the enable (EN), bit 1 the software trigger (STG, pulse), bit 2 the init/force-terminate command (INIT, pulse), bit 3 multi-link mode (MLE), and bit 7 the read-only terminal-count flag (TC). Bits 6:4 read as 0. Status reads as TC=0/EN=1 while a transfer runs, TC=0/EN=0 when the channel is aborted or idle, and TC=1 once a transfer has ended.

All ports are plain control and status signals. There is no streamed data and no valid/ready handshake. The register port accepts one access per cycle and never stalls. Read data is combinational from the selected channel.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every channel byte reads 00h, and ch_en, ch_mle, ch_stg, ch_init, req_err and wr_err are all 0.
- R2: A write updates exactly the bits whose reg_wmask bit is 1. Mask FFh is a byte write. A single-bit mask leaves the other bits unchanged.
- R3: Bit 7 (TC) ignores all writes.
- R4: An accepted read clears TC at the next edge. If a TC set event lands in the same cycle, the set wins.
- R5: With MLE=0, an eng_tc pulse clears EN at the next edge and sets TC one edge later. A read in between returns TC=0, EN=0.
- R6: With MLE=1, an eng_tc pulse leaves EN at 1 and sets TC. A hardware request (eng_req_hw=1) while TC=1 does not clear TC.
- R7: STG (bit 1) and INIT (bit 2) always read back 0. Writing 1 to either gives a one-cycle high on ch_stg or ch_init in the cycle after the write edge.
- R8: Writing INIT=1 clears EN at that write edge, whatever the MLE value.
- R9: eng_abort_ack with eng_last=1 and MLE=1 sets TC at the next edge. Without eng_last, or with MLE=0, TC stays 0.
- R10: A request while TC=1 sets the sticky req_err, unless MLE=1 and eng_req_hw=1.
- R11: While eng_suspend is 1, a write that tries to set EN or STG sets the sticky wr_err and leaves EN at its old value with no ch_stg strobe. The other masked bits are still written.
- R12: Register accesses touch only the channel selected by reg_sel, and reg_rdata shows that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | IDX_W | Channel index of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears TC) |
| reg_wmask | input | 8 | Per-bit write mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected channel byte |
| eng_tc | input | NCH | Terminal-count pulse per channel |
| eng_last | input | NCH | Engine is in the last transfer cycle |
| eng_abort_ack | input | NCH | Forced termination completed |
| eng_req | input | NCH | Transfer request seen |
| eng_req_hw | input | NCH | Request comes from a peripheral |
| eng_suspend | input | NCH | Channel is suspended |
| ch_en | output | NCH | Enable bit per channel |
| ch_mle | output | NCH | Multi-link mode per channel |
| ch_stg | output | NCH | Software trigger strobe |
| ch_init | output | NCH | Force-terminate strobe |
| req_err | output | NCH | Sticky illegal-request flag |
| wr_err | output | NCH | Sticky illegal-write flag |

## Verification
Every cycle, the embedded assertions check these properties:
- TC rises only after a terminal-count or qualifying abort event.
- A read clears TC unless a set event coincides with it.
- EN drops after terminal count without MLE and after an INIT write.
- EN survives terminal count with MLE.
- The strobes follow their write cycle.
- Both error flags are sticky.

Only the bench scenarios can show the following:
- The visible status sequence 0/1, then 0/0, then 1/x across a terminal count.
- That a hardware request under MLE leaves TC set.
- That suspended writes leave the other fields written.
- That accesses stay within the selected channel.

// File: rtl/dma_ccs_pkg.sv
package dma_ccs_pkg;
  localparam int BIT_EN   = 0;
  localparam int BIT_STG  = 1;
  localparam int BIT_INIT = 2;
  localparam int BIT_MLE  = 3;
  localparam int BIT_TC   = 7;
  localparam int REG_W    = 8;

  typedef struct packed {
    logic tc;
    logic mle;
    logic en;
  } ccs_state_t;

  function automatic logic [REG_W-1:0] ccs_view(input ccs_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_TC]  = s.tc;
    v[BIT_MLE] = s.mle;
    v[BIT_EN]  = s.en;
    return v;
  endfunction
endpackage

// File: rtl/dma_ccs_dec.sv
module dma_ccs_dec #(
  parameter int NCH   = 4,
  parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel,
  input  logic             wr,
  input  logic             rd,
  output logic [NCH-1:0]   wr_vec,
  output logic [NCH-1:0]   rd_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign wr_vec[i] = wr && (sel == IDX_W'(i));
    assign rd_vec[i] = rd && (sel == IDX_W'(i));
  end

  // R12: an access reaches at most one channel
  p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec) && $onehot0(rd_vec));
endmodule

// File: rtl/dma_ccs_rdmux.sv
module dma_ccs_rdmux #(
  parameter int NCH   = 4,
  parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int REG_W = 8
) (
  input  logic [NCH-1:0][REG_W-1:0] views,
  input  logic [IDX_W-1:0]          sel,
  output logic [REG_W-1:0]          rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (sel == IDX_W'(i)) rdata = views[i];
  end
endmodule

// File: rtl/dma_ccs_chan.sv
module dma_ccs_chan
  import dma_ccs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wmask,
  input  logic [REG_W-1:0] wdata,
  input  logic             tc_in,
  input  logic             last_in,
  input  logic             abort_ack,
  input  logic             req,
  input  logic             req_hw,
  input  logic             susp,
  output logic [REG_W-1:0] view,
  output logic             en_o,
  output logic             mle_o,
  output logic             stg_p,
  output logic             init_p,
  output logic             req_err,
  output logic             wr_err
);
  ccs_state_t st;
  logic tc_pend;
  logic en_touch, en_try, stg_try, init_hit, illegal, abort_set;
  logic unused_bits;

  assign en_touch  = wr && wmask[BIT_EN];
  assign en_try    = en_touch && wdata[BIT_EN];
  assign stg_try   = wr && wmask[BIT_STG] && wdata[BIT_STG];
  assign init_hit  = wr && wmask[BIT_INIT] && wdata[BIT_INIT];
  assign illegal   = susp && (en_try || stg_try);
  assign abort_set = abort_ack && last_in && st.mle;
  assign unused_bits = ^{wdata[6:4], wmask[6:4], wdata[BIT_TC], wmask[BIT_TC]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      tc_pend <= 1'b0;
      stg_p   <= 1'b0;
      init_p  <= 1'b0;
      req_err <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      tc_pend <= tc_in;
      // enable: init and end-of-transfer beat software writes
      if (init_hit)                        st.en <= 1'b0;
      else if (tc_in && !st.mle)           st.en <= 1'b0;
      else if (en_touch && !(susp && wdata[BIT_EN])) st.en <= wdata[BIT_EN];
      if (wr && wmask[BIT_MLE])            st.mle <= wdata[BIT_MLE];
      // terminal count: set wins over clear-on-read
      if (tc_pend || abort_set)            st.tc <= 1'b1;
      else if (rd)                         st.tc <= 1'b0;
      stg_p   <= stg_try && !susp;
      init_p  <= init_hit;
      req_err <= req_err || (req && st.tc && !(st.mle && req_hw));
      wr_err  <= wr_err || illegal;
    end
  end

  assign view  = ccs_view(st);
  assign en_o  = st.en;
  assign mle_o = st.mle;

  p_tc_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.tc) |-> $past(tc_pend || abort_set));
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && st.tc && !tc_pend && !abort_set) |=> !st.tc);
  p_end_drop_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_in && !st.mle) |=> !st.en);
  p_mle_keep_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_in && st.mle && st.en && !init_hit && !(en_touch && !wdata[BIT_EN])) |=> st.en);
  p_init_drop_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> (!st.en && init_p));
  p_stg_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stg_p |-> $past(stg_try && !susp));
  p_susp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && en_try && !st.en) |=> (!st.en && wr_err));
  p_req_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);
  p_wr_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_ccs_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wmask,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NCH-1:0]   eng_tc,
  input  logic [NCH-1:0]   eng_last,
  input  logic [NCH-1:0]   eng_abort_ack,
  input  logic [NCH-1:0]   eng_req,
  input  logic [NCH-1:0]   eng_req_hw,
  input  logic [NCH-1:0]   eng_suspend,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   ch_mle,
  output logic [NCH-1:0]   ch_stg,
  output logic [NCH-1:0]   ch_init,
  output logic [NCH-1:0]   req_err,
  output logic [NCH-1:0]   wr_err
);
  logic [NCH-1:0]            wr_vec, rd_vec;
  logic [NCH-1:0][REG_W-1:0] views;

  dma_ccs_dec #(.NCH(NCH), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
    .wr_vec(wr_vec), .rd_vec(rd_vec));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_ccs_chan u_ch (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[i]), .rd(rd_vec[i]),
      .wmask(reg_wmask), .wdata(reg_wdata),
      .tc_in(eng_tc[i]), .last_in(eng_last[i]), .abort_ack(eng_abort_ack[i]),
      .req(eng_req[i]), .req_hw(eng_req_hw[i]), .susp(eng_suspend[i]),
      .view(views[i]), .en_o(ch_en[i]), .mle_o(ch_mle[i]),
      .stg_p(ch_stg[i]), .init_p(ch_init[i]),
      .req_err(req_err[i]), .wr_err(wr_err[i]));
  end

  dma_ccs_rdmux #(.NCH(NCH), .IDX_W(IDX_W), .REG_W(REG_W)) u_rd (
    .views(views), .sel(reg_sel), .rdata(reg_rdata));

  // R1: strobes and error flags low straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (ch_stg == '0 && ch_init == '0 && req_err == '0 && wr_err == '0));
endmodule

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;
  localparam int NCH = 4;
  localparam int IW  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wmask = '0, reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] eng_tc = '0, eng_last = '0, eng_abort_ack = '0;
  logic [NCH-1:0] eng_req = '0, eng_req_hw = '0, eng_suspend = '0;
  logic [NCH-1:0] ch_en, ch_mle, ch_stg, ch_init, req_err, wr_err;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dma_chan_ctl #(.NCH(NCH), .IDX_W(IW)) u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      if (exp_q.size() == 0) chk(reg_rdata, 8'hxx, "R12 unexpected read");
      else chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int ch, input logic [7:0] m, input logic [7:0] d);
    reg_sel = IW'(ch); reg_wr = 1'b1; reg_wmask = m; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wmask = '0; reg_wdata = '0;
  endtask

  task automatic rd(input int ch, input logic [7:0] exp, input string tag);
    reg_sel = IW'(ch); reg_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    step();
    reg_rd = 1'b0;
  endtask

  task automatic tcp(input int ch);
    eng_tc[ch] = 1'b1; step(); eng_tc[ch] = 1'b0;
  endtask

  task automatic reqp(input int ch, input logic hw);
    eng_req[ch] = 1'b1; eng_req_hw[ch] = hw; step();
    eng_req[ch] = 1'b0; eng_req_hw[ch] = 1'b0;
  endtask

  task automatic abp(input int ch, input logic last);
    eng_abort_ack[ch] = 1'b1; eng_last[ch] = last; step();
    eng_abort_ack[ch] = 1'b0; eng_last[ch] = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk({ch_en, ch_mle}, 8'h00, "R1 en/mle after reset");
    chk({ch_stg, ch_init}, 8'h00, "R1 strobes after reset");
    chk({req_err, wr_err}, 8'h00, "R1 errors after reset");
    for (int c = 0; c < NCH; c++) rd(c, 8'h00, "R1 reset byte");

    wr(0, 8'hFF, 8'h89);
    rd(0, 8'h09, "R3 byte write ignores TC");
    chk({7'd0, ch_en[0]}, 8'h01, "R2 en out");
    wr(0, 8'h08, 8'h00);
    rd(0, 8'h01, "R2 single-bit write");

    tcp(0);
    rd(0, 8'h00, "R5 transient 0/0");
    rd(0, 8'h80, "R5 TC set after EN clear");
    rd(0, 8'h00, "R4 read clears TC");

    wr(0, 8'hFF, 8'h81);
    rd(0, 8'h01, "R3 TC write ignored");
    tcp(0); step();
    wr(0, 8'h80, 8'h00);
    rd(0, 8'h80, "R3 TC clear by write ignored");
    rd(0, 8'h00, "R4 TC cleared");

    wr(0, 8'hFF, 8'h09);
    tcp(0); step();
    reqp(0, 1'b1);
    chk({7'd0, req_err[0]}, 8'h00, "R10 MLE hw request no error");
    rd(0, 8'h89, "R6 EN kept, TC held on hw request");
    rd(0, 8'h09, "R6 after clear");
    tcp(0); step();
    reqp(0, 1'b0);
    chk({7'd0, req_err[0]}, 8'h01, "R10 sw request with TC set");
    rd(0, 8'h89, "R10 state");
    step();
    chk({7'd0, req_err[0]}, 8'h01, "R10 sticky");

    wr(1, 8'h02, 8'h02);
    chk({7'd0, ch_stg[1]}, 8'h01, "R7 STG strobe");
    step();
    chk({7'd0, ch_stg[1]}, 8'h00, "R7 STG one cycle");
    rd(1, 8'h00, "R7 STG reads 0");

    wr(2, 8'hFF, 8'h09);
    rd(2, 8'h09, "R12 ch2 write");
    wr(2, 8'h04, 8'h04);
    chk({ch_init[2], ch_en[2]}, 8'h02, "R8 INIT strobe and EN clear");
    step();
    chk({7'd0, ch_init[2]}, 8'h00, "R7 INIT one cycle");
    rd(2, 8'h08, "R8 EN cleared despite MLE");
    abp(2, 1'b1);
    rd(2, 8'h88, "R9 abort in last cycle with MLE");
    rd(2, 8'h08, "R9 cleared");
    abp(2, 1'b0);
    rd(2, 8'h08, "R9 abort without last");

    eng_suspend[3] = 1'b1;
    wr(3, 8'hFF, 8'h0B);
    chk({wr_err[3], ch_stg[3], ch_en[3]}, 8'h04, "R11 suspended write flagged");
    rd(3, 8'h08, "R11 EN blocked, MLE written");
    eng_suspend[3] = 1'b0;
    wr(3, 8'h01, 8'h01);
    rd(3, 8'h09, "R11 legal write after resume");

    rd(1, 8'h00, "R12 ch1 untouched");
    wr(1, 8'h08, 8'h08);
    rd(0, 8'h09, "R12 ch0 unaffected");
    rd(1, 8'h08, "R12 ch1 written");

    step(); step();
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R12 reads pending");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule